// File: doc/BRIEF.md
# Masked Bidirectional Controller Port

The block is a memory-mapped peripheral that gives a host three 8-bit parallel ports for game-pad style controllers. Each port has a data register and a direction register. Seven of the data bits reach a pin, and the direction register marks each of those pins as driven (1) or sampled (0). The eighth data bit, bit 7, is a latched bit that no pin carries. A read-only revision register and nine plain storage registers complete the map. The storage registers are transmit, receive and serial setup bytes for each port. They only store values, and no serial shifting happens.

The host bus is 16 bits wide and every register is 8 bits wide. A write takes the low byte of the write data. A read returns the register byte in both halves of the bus. A data-register write changes only the bits that the direction register marks as outputs. The written data bit 6 appears on drive pin 6. When that pin is driven, it acts as the select line for a pad wired behind the port, and the pad then presents a different group of inputs.

Register indices: 0 revision. 1, 2, 3 data of ports A, B, C. 4, 5, 6 direction of ports A, B, C. 7, 8, 9 transmit, receive and serial setup of port A. 10 to 12 the same three for port B. 13 to 15 the same three for port C.

Top module: `ctlport_top`

## Requirements
- R1: After reset every register is 0, so every pin is an input. drv_en and drv_val are all 0 and rd_data is 0.
- R2: When rd_en is high at a clock edge, the addressed byte is captured and appears on rd_data after that edge. While rd_en is low, rd_data holds its value.
- R3: rd_data[15:8] always equals rd_data[7:0].
- R4: Index 0 reads as the VERSION parameter (default 0x80: bit 7 region flag set, bit 6 video flag clear, bit 5 add-on-absent flag clear, bit 4 zero, bits 3..0 revision 0). Writes to index 0 have no effect.
- R5: A write to a data index (1 to 3) sets the register to (wr_data[7:0] AND dir) OR (old AND NOT dir). Bits whose direction bit is 0 keep their value.
- R6: A data read returns the latched value in bit 7. In bits 6..0 it returns the latched bit where the direction bit is 1 and the live pin where it is 0.
- R7: Direction registers (indices 4 to 6) store wr_data[7:0] unmodified and read back as stored. drv_en of port p is bits 6..0 of its direction register.
- R8: drv_val of port p is bits 6..0 of its latched data register. Bit 6 is the pad select line.
- R9: Indices 7 to 15 store wr_data[7:0] unmodified and read back as stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 4 | Register index |
| wr_data | input | 16 | Write data; the low byte is used |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| pin_in | input | 21 | Pin levels, 7 per port; port p is at [7p+6:7p] |
| rd_data | output | 16 | Read data, byte mirrored in both halves |
| drv_val | output | 21 | Pin drive values, 7 per port |
| drv_en | output | 21 | Pin drive enables, 7 per port |

## Verification
The assertions assume that reg_idx, wr_data, wr_en, rd_en and pin_in are settled at each rising edge. They assume that a write and a read are not issued to the same index in the same cycle. The checks have no view of which of those two is ordered first. The stimulus changes every input on the falling edge and issues one access at a time, so both assumptions hold.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;
  localparam int REG_W        = 8;
  localparam int BUS_W        = 16;
  localparam int IDX_W        = 4;
  localparam int SER_PER_PORT = 3;
  localparam int IDX_VER      = 0;
  localparam int IDX_DATA0    = 1;
endpackage

// File: rtl/ctlport_lane.sv
module ctlport_lane #(
  parameter int PIN_W = 7,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_we,
  input  logic             dir_we,
  input  logic [REG_W-1:0] wdata,
  input  logic [PIN_W-1:0] pin_in,
  output logic [REG_W-1:0] rd_view,
  output logic [REG_W-1:0] dir_view,
  output logic [PIN_W-1:0] drv_val,
  output logic [PIN_W-1:0] drv_en
);
  logic [REG_W-1:0] data_q;
  logic [REG_W-1:0] dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (data_we) data_q <= (wdata & dir_q) | (data_q & ~dir_q);
      if (dir_we)  dir_q  <= wdata;
    end
  end

  assign rd_view  = {data_q[REG_W-1:PIN_W],
                     (data_q[PIN_W-1:0] & dir_q[PIN_W-1:0]) |
                     (pin_in & ~dir_q[PIN_W-1:0])};
  assign dir_view = dir_q;
  assign drv_val  = data_q[PIN_W-1:0];
  assign drv_en   = dir_q[PIN_W-1:0];

  // input bits never change through any cycle
  assert_input_bits_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((data_q ^ $past(data_q)) & ~$past(dir_q)) == '0));

  assert_drive_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !data_we |=> $stable(drv_val));
endmodule

// File: rtl/ctlport_store.sv
module ctlport_store #(
  parameter int DEPTH = 9,
  parameter int REG_W = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we && int'(addr) < DEPTH) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = (int'(addr) < DEPTH) ? mem_q[addr] : '0;

  assert_store_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(addr) < DEPTH) |=> (mem_q[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/ctlport_top.sv
module ctlport_top
  import ctlport_pkg::*;
#(
  parameter int          NUM_PORTS = 3,
  parameter int          PIN_W     = 7,
  parameter logic [7:0]  VERSION   = 8'h80,
  localparam int         PINS_W    = NUM_PORTS * PIN_W,
  localparam int         IDX_DIR0  = IDX_DATA0 + NUM_PORTS,
  localparam int         IDX_SER0  = IDX_DIR0 + NUM_PORTS,
  localparam int         NUM_SER   = NUM_PORTS * SER_PER_PORT,
  localparam int         SER_AW    = (NUM_SER > 1) ? $clog2(NUM_SER) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [PINS_W-1:0] pin_in,
  output logic [BUS_W-1:0]  rd_data,
  output logic [PINS_W-1:0] drv_val,
  output logic [PINS_W-1:0] drv_en
);
  logic [REG_W-1:0] wbyte;
  logic [REG_W-1:0] lane_rd  [NUM_PORTS];
  logic [REG_W-1:0] lane_dir [NUM_PORTS];
  logic [REG_W-1:0] ser_rd;
  logic [REG_W-1:0] rd_byte;
  logic [REG_W-1:0] rd_q;
  logic [IDX_W-1:0] ser_off;
  logic             ser_hit;

  assign wbyte   = wr_data[REG_W-1:0];
  assign ser_off = reg_idx - IDX_W'(IDX_SER0);
  assign ser_hit = (int'(reg_idx) >= IDX_SER0) && (int'(reg_idx) < IDX_SER0 + NUM_SER);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
    logic data_we, dir_we;
    assign data_we = wr_en && (int'(reg_idx) == IDX_DATA0 + p);
    assign dir_we  = wr_en && (int'(reg_idx) == IDX_DIR0 + p);
    ctlport_lane #(.PIN_W(PIN_W), .REG_W(REG_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_we  (data_we),
      .dir_we   (dir_we),
      .wdata    (wbyte),
      .pin_in   (pin_in[p*PIN_W +: PIN_W]),
      .rd_view  (lane_rd[p]),
      .dir_view (lane_dir[p]),
      .drv_val  (drv_val[p*PIN_W +: PIN_W]),
      .drv_en   (drv_en[p*PIN_W +: PIN_W])
    );
  end

  ctlport_store #(.DEPTH(NUM_SER), .REG_W(REG_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en && ser_hit),
    .addr  (ser_off[SER_AW-1:0]),
    .wdata (wbyte),
    .rdata (ser_rd)
  );

  always_comb begin
    rd_byte = 8'hE0;
    if (int'(reg_idx) == IDX_VER) rd_byte = VERSION;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (int'(reg_idx) == IDX_DATA0 + p) rd_byte = lane_rd[p];
      if (int'(reg_idx) == IDX_DIR0 + p)  rd_byte = lane_dir[p];
    end
    if (ser_hit) rd_byte = ser_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_byte;
  end

  assign rd_data = {rd_q, rd_q};

  assert_byte_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:8] == rd_data[7:0]);

  assert_read_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  assert_version_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(reg_idx) == IDX_VER) |=> (rd_data[7:0] == VERSION));
endmodule

// File: tb/tb_ctlport_top.sv
module tb_ctlport_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [15:0] wr_data = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [20:0] pin_in = '0;
  logic [15:0] rd_data;
  logic [20:0] drv_val, drv_en;

  ctlport_top dut (.clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_data(wr_data),
                   .wr_en(wr_en), .rd_en(rd_en), .pin_in(pin_in), .rd_data(rd_data),
                   .drv_val(drv_val), .drv_en(drv_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] m_data [3];
  logic [7:0] m_dir  [3];
  logic [7:0] m_ser  [9];

  // {wr, idx, wdata, pinC, pinB, pinA}
  localparam logic [33:0] VECS [NV] = '{
    {1'b1, 4'd4,  8'h0F, 7'h00, 7'h00, 7'h00},
    {1'b1, 4'd1,  8'hFF, 7'h00, 7'h00, 7'h00},
    {1'b0, 4'd1,  8'h00, 7'h00, 7'h00, 7'h55},
    {1'b1, 4'd1,  8'hA0, 7'h00, 7'h00, 7'h55},
    {1'b0, 4'd1,  8'h00, 7'h00, 7'h00, 7'h7F},
    {1'b1, 4'd5,  8'hC3, 7'h00, 7'h00, 7'h00},
    {1'b1, 4'd2,  8'hFF, 7'h00, 7'h00, 7'h00},
    {1'b0, 4'd2,  8'h00, 7'h00, 7'h2A, 7'h00},
    {1'b0, 4'd5,  8'h00, 7'h00, 7'h2A, 7'h00},
    {1'b1, 4'd6,  8'hFF, 7'h00, 7'h00, 7'h00},
    {1'b1, 4'd3,  8'h5A, 7'h00, 7'h00, 7'h00},
    {1'b0, 4'd3,  8'h00, 7'h7F, 7'h00, 7'h00},
    {1'b1, 4'd6,  8'h00, 7'h7F, 7'h00, 7'h00},
    {1'b0, 4'd3,  8'h00, 7'h7F, 7'h00, 7'h00},
    {1'b1, 4'd3,  8'h00, 7'h7F, 7'h00, 7'h00},
    {1'b0, 4'd3,  8'h00, 7'h11, 7'h00, 7'h00},
    {1'b1, 4'd7,  8'h11, 7'h00, 7'h00, 7'h00},
    {1'b1, 4'd11, 8'h22, 7'h00, 7'h00, 7'h00},
    {1'b1, 4'd15, 8'h33, 7'h00, 7'h00, 7'h00},
    {1'b0, 4'd7,  8'h00, 7'h00, 7'h00, 7'h00},
    {1'b0, 4'd11, 8'h00, 7'h00, 7'h00, 7'h00},
    {1'b0, 4'd15, 8'h00, 7'h00, 7'h00, 7'h00}
  };

  function automatic string tag_of(input int idx);
    if (idx == 0) return "R4";
    if (idx <= 3) return "R6";
    if (idx <= 6) return "R7";
    return "R9";
  endfunction

  function automatic logic [7:0] model_read(input int idx, input logic [20:0] pins);
    if (idx == 0) return 8'h80;
    if (idx <= 3) begin
      logic [6:0] pv, dv;
      pv = pins[(idx-1)*7 +: 7];
      dv = m_dir[idx-1][6:0];
      return {m_data[idx-1][7], (m_data[idx-1][6:0] & dv) | (pv & ~dv)};
    end
    if (idx <= 6) return m_dir[idx-4];
    return m_ser[idx-7];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin m_data[i] = '0; m_dir[i] = '0; end
    for (int i = 0; i < 9; i++) m_ser[i] = '0;
  endtask

  task automatic model_write(input int idx, input logic [7:0] d);
    if (idx >= 1 && idx <= 3) m_data[idx-1] = (d & m_dir[idx-1]) | (m_data[idx-1] & ~m_dir[idx-1]);
    else if (idx >= 4 && idx <= 6) m_dir[idx-4] = d;
    else if (idx >= 7) m_ser[idx-7] = d;
  endtask

  task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input int idx, input logic [7:0] d);
    @(negedge clk);
    reg_idx = 4'(idx); wr_data = {8'hA5, d}; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(idx, d);
  endtask

  task automatic do_read(input int idx, input logic [20:0] pins, input string req);
    logic [7:0] e;
    @(negedge clk);
    reg_idx = 4'(idx); pin_in = pins; rd_en = 1'b1;
    e = model_read(idx, pins);
    @(negedge clk);
    rd_en = 1'b0;
    check(req, 21'(rd_data), 21'({e, e}));
  endtask

  function automatic logic [20:0] m_drv_val();
    return {m_data[2][6:0], m_data[1][6:0], m_data[0][6:0]};
  endfunction
  function automatic logic [20:0] m_drv_en();
    return {m_dir[2][6:0], m_dir[1][6:0], m_dir[0][6:0]};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", 21'(rd_data), 21'h0);
    check("R1", drv_val, 21'h0);
    check("R1", drv_en, 21'h0);
    rst_n = 1'b1;
    do_read(1, 21'h0, "R1");
    do_read(4, 21'h0, "R1");

    for (int v = 0; v < NV; v++) begin
      logic [33:0] t;
      t = VECS[v];
      if (t[33]) begin
        do_write(int'(t[32:29]), t[28:21]);
        check("R8", drv_val, m_drv_val());
        check("R7", drv_en, m_drv_en());
      end else begin
        do_read(int'(t[32:29]), t[20:0], tag_of(int'(t[32:29])));
      end
    end

    // R4: version read, write ignored
    do_write(0, 8'h3C);
    do_read(0, 21'h0, "R4");
    // R3: both halves equal after a mixed value
    do_write(13, 8'h96);
    do_read(13, 21'h0, "R3");
    // R2: output holds while rd_en is low
    begin
      logic [15:0] held;
      held = rd_data;
      @(negedge clk); reg_idx = 4'd0; pin_in = 21'h1FFFFF;
      repeat (3) @(negedge clk);
      check("R2", 21'(rd_data), 21'(held));
    end
    // R6: bit 7 is latched, never a pin
    do_write(4, 8'h80);
    do_write(1, 8'hFF);
    do_read(1, 21'h000000, "R6");
    // R5: write with all inputs leaves data unchanged
    do_write(5, 8'h00);
    do_write(2, 8'hFF);
    check("R5", drv_val, m_drv_val());
    do_read(2, 21'h0, "R5");
    // R1: reset again mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1", drv_en, 21'h0);
    check("R1", 21'(rd_data), 21'h0);
    rst_n = 1'b1;
    model_reset();
    do_read(7, 21'h0, "R1");
    do_read(6, 21'h0, "R1");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule